// File: doc/BRIEF.md
# Platform Power State Sequencer

This block is a synchronous state machine that walks a computing platform through four steady power states: off, soft-off, suspend and run. It moves between them through transitional sequences. Each sequence switches the platform rails in a set order: the standby regulator, the memory rail, the 5 V rail, the 3.3 V rail and the core rail. Each sequence also inserts its own fixed delays and waits for the rail power-good inputs. The machine also drives the resume-reset release and the system and core power-good outputs toward the platform controller.

Upward moves are requested by a power-on input and by two wake-request inputs from the platform controller. The deep wake lets the platform leave soft-off, and the light wake lets it leave suspend. Every wait is measured by one reloadable cycle counter, scaled by `CLKS_PER_MS` clock cycles per millisecond. A wait for power-good that runs past its timeout counts as failed, and each such wait has a fallback path. A rail lost during suspend or run forces a shutdown. If the platform reset never releases after power-good, the machine shuts down and restarts by itself through soft-off. The restart pulses a power-button output.

Top module: `pwrseq_top`

## Requirements
- R1: After reset, every rail enable, `rsm_rel_o`, both power-good outputs and `pwr_btn_o` are 0, and `state_o` is 0. `state_o` uses these codes: 0 off, 1 soft-off, 2 suspend, 3 run, 4 off-to-soft, 5 soft-to-suspend, 6 suspend-to-run, 7 run-to-suspend, 8 suspend-to-soft, 9 soft-to-off.
- R2: `pwr_on_req_i` high in off enters state 4. The standby enable rises 10 ms later. Once `pg_stby_i` is high, `rsm_rel_o` rises one cycle after that. State 1 follows a further 10 ms later.
- R3: If `pg_stby_i` stays low for `GOOD_TO_MS` after the standby enable rises, the standby enable and `rsm_rel_o` drop and the machine returns to off.
- R4: `deep_wake_i` high in soft-off enters state 5 and sets the memory enable in the same cycle. While `pg_stby_i` is high, suspend follows one cycle later.
- R5: `lite_wake_i` high in suspend enters state 6 with the 5 V enable set. The 3.3 V enable follows 3 ms later.
- R6: With `pg_5v_i` and `pg_stby_i` high, the core enable rises one cycle after the 3.3 V enable. Both power-good outputs rise together 15 ms later. A power-good output is never high while the core enable is low.
- R7: After power-good, `plt_rst_i` is sampled at the end of each 1 ms window. When it is found low, run is entered at that point, so at the earliest 1 ms after power-good.
- R8: Run with `lite_wake_i` low enters state 7 and drops both power-good outputs. The core enable drops `PWROK_GAP_CYC` cycles later. After a further 7 ms the 3.3 V enable drops and suspend is entered. The 5 V enable drops at that point too, unless `keep_usb_i` is high.
- R9: Suspend with `deep_wake_i` low enters state 8, which drops the 5 V and memory enables. If `pause_soft_i` is high, soft-off follows one cycle later with the standby enable kept on.
- R10: With `pause_soft_i` low, state 8 is followed one cycle later by state 9. One cycle after that the machine is in off, with the standby enable and `rsm_rel_o` both low.
- R11: Loss of `pg_5v_i` or `pg_stby_i` in run, or loss of `pg_stby_i` in suspend, forces a shutdown. `sys_pg_o` and `rsm_rel_o` drop as the machine enters state 7 or 8.
- R12: If the rails are not good within `GOOD_TO_MS` after the 3.3 V enable rises in state 6, both the 5 V and 3.3 V enables drop and `rsm_rel_o` drops, and suspend is re-entered in that same cycle.
- R13: If `plt_rst_i` is still high after `PLT_POLLS` windows, run is entered with `sys_pg_o` and `rsm_rel_o` low. The next pass through state 8 waits 100 ms, pulses `pwr_btn_o` for one cycle and enters state 4 in the same cycle.
- R14: A `dbg_plt_fail_i` pulse makes the next poll outcome a timeout even though `plt_rst_i` is low. The effect applies once only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_on_req_i | input | 1 | Power-on request, sampled in off |
| deep_wake_i | input | 1 | Deep-sleep exit request from platform controller |
| lite_wake_i | input | 1 | Light-sleep exit request from platform controller |
| pg_stby_i | input | 1 | Standby rail power good |
| pg_5v_i | input | 1 | 5 V rail power good |
| plt_rst_i | input | 1 | Platform reset still asserted, active high |
| keep_usb_i | input | 1 | Keep 5 V rail on in suspend |
| pause_soft_i | input | 1 | Stop shutdown in soft-off instead of off |
| dbg_plt_fail_i | input | 1 | Arm a simulated platform-reset timeout |
| stby_en_o | output | 1 | Standby regulator enable |
| mem_en_o | output | 1 | Memory rail enable |
| v5_en_o | output | 1 | 5 V rail enable |
| v3_en_o | output | 1 | 3.3 V rail enable |
| core_en_o | output | 1 | Core rail enable |
| rsm_rel_o | output | 1 | Resume reset release |
| sys_pg_o | output | 1 | System power good to platform controller |
| core_pg_o | output | 1 | Core power good to platform controller |
| pwr_btn_o | output | 1 | One-cycle power-button pulse for restart |
| state_o | output | 4 | Current state code |

## Verification
A wrong internal state becomes visible in two ways. One is a `state_o` code that differs from the expected one. The other is a rail enable or power-good output that changes in the wrong cycle. Because every action is registered on the edge that enters a step, a corrupted step or timer value shifts the next edge away from its exact count: N ms becomes N·`CLKS_PER_MS` cycles after the previous edge. The bench measures these offsets to the cycle. A corrupted restart or debug flag shows up only at the next pass through state 8 or the next poll outcome. It can therefore stay hidden for a whole power cycle.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [3:0] {
    ST_OFF       = 4'd0,
    ST_SOFT      = 4'd1,
    ST_SUSP      = 4'd2,
    ST_RUN       = 4'd3,
    ST_OFF_SOFT  = 4'd4,
    ST_SOFT_SUSP = 4'd5,
    ST_SUSP_RUN  = 4'd6,
    ST_RUN_SUSP  = 4'd7,
    ST_SUSP_SOFT = 4'd8,
    ST_SOFT_OFF  = 4'd9
  } pwr_state_e;

  typedef struct packed {
    logic stby;
    logic mem;
    logic v5;
    logic v3;
    logic core;
    logic rsm;
    logic sys_pg;
    logic core_pg;
    logic btn;
  } ctl_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [TW-1:0] load_i,
  output logic          exp_o
);

  logic [TW-1:0] rem_q;

  // loaded with cycles-1 so a wait of N cycles expires in its Nth cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            rem_q <= '0;
    else if (start_i)       rem_q <= load_i;
    else if (rem_q != '0)   rem_q <= rem_q - 1'b1;
  end

  assign exp_o = (rem_q == '0);

endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
  import pwrseq_pkg::*;
#(
  parameter int CLKS_PER_MS   = 125000,
  parameter int T_STBY_MS     = 10,
  parameter int T_SUSCLK_MS   = 10,
  parameter int T_5V3V_MS     = 3,
  parameter int T_CORE_MS     = 15,
  parameter int T_RAILOFF_MS  = 7,
  parameter int T_RESTART_MS  = 100,
  parameter int GOOD_TO_MS    = 100,
  parameter int PLT_POLLS     = 50,
  parameter int PWROK_GAP_CYC = 5,
  parameter int TW            = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pwr_on_req_i,
  input  logic          deep_wake_i,
  input  logic          lite_wake_i,
  input  logic          pg_stby_i,
  input  logic          pg_5v_i,
  input  logic          plt_rst_i,
  input  logic          keep_usb_i,
  input  logic          pause_soft_i,
  input  logic          dbg_plt_fail_i,
  input  logic          tmr_exp_i,
  output logic          tmr_start_o,
  output logic [TW-1:0] tmr_load_o,
  output ctl_t          ctl_o,
  output pwr_state_e    state_o
);

  localparam int PW = $clog2(PLT_POLLS + 1);
  localparam logic [TW-1:0] L_STBY    = TW'(T_STBY_MS * CLKS_PER_MS - 1);
  localparam logic [TW-1:0] L_SUSCLK  = TW'(T_SUSCLK_MS * CLKS_PER_MS - 1);
  localparam logic [TW-1:0] L_5V3V    = TW'(T_5V3V_MS * CLKS_PER_MS - 1);
  localparam logic [TW-1:0] L_CORE    = TW'(T_CORE_MS * CLKS_PER_MS - 1);
  localparam logic [TW-1:0] L_RAILOFF = TW'(T_RAILOFF_MS * CLKS_PER_MS - 1);
  localparam logic [TW-1:0] L_RESTART = TW'(T_RESTART_MS * CLKS_PER_MS - 1);
  localparam logic [TW-1:0] L_GOOD    = TW'(GOOD_TO_MS * CLKS_PER_MS - 1);
  localparam logic [TW-1:0] L_MS      = TW'(CLKS_PER_MS - 1);
  localparam logic [TW-1:0] L_GAP     = TW'(PWROK_GAP_CYC - 1);
  localparam logic [PW-1:0] POLL_LAST = PW'(PLT_POLLS - 1);

  pwr_state_e    st_q, st_d;
  logic [1:0]    step_q, step_d;
  logic [PW-1:0] poll_q, poll_d;
  logic          restart_q, restart_d;
  logic          fake_q, fake_d;
  ctl_t          ctl_q, ctl_d;

  always_comb begin
    st_d        = st_q;
    step_d      = step_q;
    poll_d      = poll_q;
    restart_d   = restart_q;
    fake_d      = fake_q | dbg_plt_fail_i;
    ctl_d       = ctl_q;
    ctl_d.btn   = 1'b0;
    tmr_start_o = 1'b0;
    tmr_load_o  = '0;
    unique case (st_q)
      ST_OFF: if (pwr_on_req_i) begin
        st_d = ST_OFF_SOFT; tmr_start_o = 1'b1; tmr_load_o = L_STBY;
      end
      ST_OFF_SOFT: begin
        unique case (step_q)
          2'd0: if (tmr_exp_i) begin
            ctl_d.stby = 1'b1; step_d = 2'd1;
            tmr_start_o = 1'b1; tmr_load_o = L_GOOD;
          end
          2'd1: begin
            if (pg_stby_i) begin
              ctl_d.rsm = 1'b1; step_d = 2'd2;
              tmr_start_o = 1'b1; tmr_load_o = L_SUSCLK;
            end else if (tmr_exp_i) begin
              ctl_d.stby = 1'b0; ctl_d.rsm = 1'b0; ctl_d.sys_pg = 1'b0;
              st_d = ST_OFF;
            end
          end
          default: if (tmr_exp_i) st_d = ST_SOFT;
        endcase
      end
      ST_SOFT: if (deep_wake_i) begin
        ctl_d.mem = 1'b1; st_d = ST_SOFT_SUSP;
        tmr_start_o = 1'b1; tmr_load_o = L_GOOD;
      end
      ST_SOFT_SUSP: begin
        if (pg_stby_i) st_d = ST_SUSP;
        else if (tmr_exp_i) begin
          ctl_d.mem = 1'b0; ctl_d.rsm = 1'b0; ctl_d.sys_pg = 1'b0;
          st_d = ST_SOFT_OFF;
        end
      end
      ST_SUSP: begin
        if (!pg_stby_i || (!lite_wake_i && !deep_wake_i)) begin
          if (!pg_stby_i) begin
            ctl_d.rsm = 1'b0; ctl_d.sys_pg = 1'b0;
          end
          ctl_d.v5 = 1'b0; ctl_d.mem = 1'b0; st_d = ST_SUSP_SOFT;
          tmr_start_o = 1'b1; tmr_load_o = L_RESTART;
        end else if (lite_wake_i) begin
          ctl_d.v5 = 1'b1; st_d = ST_SUSP_RUN;
          tmr_start_o = 1'b1; tmr_load_o = L_5V3V;
        end
      end
      ST_SUSP_RUN: begin
        unique case (step_q)
          2'd0: if (tmr_exp_i) begin
            ctl_d.v3 = 1'b1; step_d = 2'd1;
            tmr_start_o = 1'b1; tmr_load_o = L_GOOD;
          end
          2'd1: begin
            if (pg_5v_i && pg_stby_i) begin
              ctl_d.core = 1'b1; step_d = 2'd2;
              tmr_start_o = 1'b1; tmr_load_o = L_CORE;
            end else if (tmr_exp_i) begin
              ctl_d.v5 = 1'b0; ctl_d.v3 = 1'b0;
              ctl_d.rsm = 1'b0; ctl_d.sys_pg = 1'b0;
              st_d = ST_SUSP;
            end
          end
          2'd2: if (tmr_exp_i) begin
            ctl_d.sys_pg = 1'b1; ctl_d.core_pg = 1'b1; step_d = 2'd3;
            poll_d = '0; tmr_start_o = 1'b1; tmr_load_o = L_MS;
          end
          default: if (tmr_exp_i) begin
            if (!plt_rst_i && !fake_q) begin
              st_d = ST_RUN;
            end else if (!plt_rst_i || poll_q == POLL_LAST) begin
              // never released, or a simulated failure was armed
              ctl_d.rsm = 1'b0; ctl_d.sys_pg = 1'b0;
              restart_d = 1'b1; fake_d = 1'b0; st_d = ST_RUN;
            end else begin
              poll_d = poll_q + 1'b1;
              tmr_start_o = 1'b1; tmr_load_o = L_MS;
            end
          end
        endcase
      end
      ST_RUN: if (!(pg_5v_i && pg_stby_i) || !lite_wake_i) begin
        ctl_d.sys_pg = 1'b0; ctl_d.core_pg = 1'b0;
        if (!(pg_5v_i && pg_stby_i)) ctl_d.rsm = 1'b0;
        st_d = ST_RUN_SUSP; tmr_start_o = 1'b1; tmr_load_o = L_GAP;
      end
      ST_RUN_SUSP: begin
        if (step_q == 2'd0) begin
          if (tmr_exp_i) begin
            ctl_d.core = 1'b0; step_d = 2'd1;
            tmr_start_o = 1'b1; tmr_load_o = L_RAILOFF;
          end
        end else if (tmr_exp_i) begin
          ctl_d.v3 = 1'b0;
          if (!keep_usb_i) ctl_d.v5 = 1'b0;
          st_d = ST_SUSP;
        end
      end
      ST_SUSP_SOFT: begin
        if (!restart_q) begin
          st_d = pause_soft_i ? ST_SOFT : ST_SOFT_OFF;
        end else if (tmr_exp_i) begin
          restart_d = 1'b0; ctl_d.btn = 1'b1; st_d = ST_OFF_SOFT;
          tmr_start_o = 1'b1; tmr_load_o = L_STBY;
        end
      end
      ST_SOFT_OFF: begin
        ctl_d.stby = 1'b0; ctl_d.rsm = 1'b0; st_d = ST_OFF;
      end
      default: st_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_OFF;
      step_q    <= '0;
      poll_q    <= '0;
      restart_q <= 1'b0;
      fake_q    <= 1'b0;
      ctl_q     <= '0;
    end else begin
      st_q      <= st_d;
      step_q    <= (st_d != st_q) ? 2'd0 : step_d;
      poll_q    <= poll_d;
      restart_q <= restart_d;
      fake_q    <= fake_d;
      ctl_q     <= ctl_d;
    end
  end

  assign ctl_o   = ctl_q;
  assign state_o = st_q;

endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top
  import pwrseq_pkg::*;
#(
  parameter int CLKS_PER_MS   = 125000,
  parameter int T_STBY_MS     = 10,
  parameter int T_SUSCLK_MS   = 10,
  parameter int T_5V3V_MS     = 3,
  parameter int T_CORE_MS     = 15,
  parameter int T_RAILOFF_MS  = 7,
  parameter int T_RESTART_MS  = 100,
  parameter int GOOD_TO_MS    = 100,
  parameter int PLT_POLLS     = 50,
  parameter int PWROK_GAP_CYC = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwr_on_req_i,
  input  logic       deep_wake_i,
  input  logic       lite_wake_i,
  input  logic       pg_stby_i,
  input  logic       pg_5v_i,
  input  logic       plt_rst_i,
  input  logic       keep_usb_i,
  input  logic       pause_soft_i,
  input  logic       dbg_plt_fail_i,
  output logic       stby_en_o,
  output logic       mem_en_o,
  output logic       v5_en_o,
  output logic       v3_en_o,
  output logic       core_en_o,
  output logic       rsm_rel_o,
  output logic       sys_pg_o,
  output logic       core_pg_o,
  output logic       pwr_btn_o,
  output logic [3:0] state_o
);

  localparam int MAX_MS = imax(imax(imax(GOOD_TO_MS, T_RESTART_MS), imax(T_STBY_MS, T_SUSCLK_MS)),
                               imax(imax(T_5V3V_MS, T_CORE_MS), T_RAILOFF_MS));
  localparam int MAX_CYC = imax(MAX_MS * CLKS_PER_MS, PWROK_GAP_CYC);
  localparam int TW      = $clog2(MAX_CYC + 1);

  logic          tmr_start, tmr_exp;
  logic [TW-1:0] tmr_load;
  ctl_t          ctl;
  pwr_state_e    st;

  pwrseq_timer #(.TW(TW)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (tmr_start),
    .load_i  (tmr_load),
    .exp_o   (tmr_exp)
  );

  pwrseq_fsm #(
    .CLKS_PER_MS   (CLKS_PER_MS),
    .T_STBY_MS     (T_STBY_MS),
    .T_SUSCLK_MS   (T_SUSCLK_MS),
    .T_5V3V_MS     (T_5V3V_MS),
    .T_CORE_MS     (T_CORE_MS),
    .T_RAILOFF_MS  (T_RAILOFF_MS),
    .T_RESTART_MS  (T_RESTART_MS),
    .GOOD_TO_MS    (GOOD_TO_MS),
    .PLT_POLLS     (PLT_POLLS),
    .PWROK_GAP_CYC (PWROK_GAP_CYC),
    .TW            (TW)
  ) u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .pwr_on_req_i   (pwr_on_req_i),
    .deep_wake_i    (deep_wake_i),
    .lite_wake_i    (lite_wake_i),
    .pg_stby_i      (pg_stby_i),
    .pg_5v_i        (pg_5v_i),
    .plt_rst_i      (plt_rst_i),
    .keep_usb_i     (keep_usb_i),
    .pause_soft_i   (pause_soft_i),
    .dbg_plt_fail_i (dbg_plt_fail_i),
    .tmr_exp_i      (tmr_exp),
    .tmr_start_o    (tmr_start),
    .tmr_load_o     (tmr_load),
    .ctl_o          (ctl),
    .state_o        (st)
  );

  assign stby_en_o = ctl.stby;
  assign mem_en_o  = ctl.mem;
  assign v5_en_o   = ctl.v5;
  assign v3_en_o   = ctl.v3;
  assign core_en_o = ctl.core;
  assign rsm_rel_o = ctl.rsm;
  assign sys_pg_o  = ctl.sys_pg;
  assign core_pg_o = ctl.core_pg;
  assign pwr_btn_o = ctl.btn;
  assign state_o   = st;

endmodule

// File: rtl/pwrseq_chk.sv
module pwrseq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       stby_en_o,
  input logic       mem_en_o,
  input logic       v5_en_o,
  input logic       v3_en_o,
  input logic       core_en_o,
  input logic       rsm_rel_o,
  input logic       sys_pg_o,
  input logic       core_pg_o,
  input logic       pwr_btn_o,
  input logic [3:0] state_o
);

  p_pg_needs_core_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sys_pg_o || core_pg_o) |-> core_en_o);

  p_run_has_core_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 4'd3) |-> core_en_o);

  p_v3_needs_v5_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v3_en_o |-> v5_en_o);

  p_mem_needs_stby_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o |-> stby_en_o);

  p_rsm_needs_stby_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsm_rel_o |-> stby_en_o);

  p_pg_before_core_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(core_en_o) |-> $past(!sys_pg_o && !core_pg_o));

  p_btn_single_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_btn_o |=> !pwr_btn_o);

  p_btn_enters_up_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_btn_o |-> (state_o == 4'd4));

endmodule

bind pwrseq_top pwrseq_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .stby_en_o (stby_en_o),
  .mem_en_o  (mem_en_o),
  .v5_en_o   (v5_en_o),
  .v3_en_o   (v3_en_o),
  .core_en_o (core_en_o),
  .rsm_rel_o (rsm_rel_o),
  .sys_pg_o  (sys_pg_o),
  .core_pg_o (core_pg_o),
  .pwr_btn_o (pwr_btn_o),
  .state_o   (state_o)
);

// File: tb/tb_pwrseq_top.sv
module tb_pwrseq_top;

  localparam int K = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pwr_on_req_i = 0, deep_wake_i = 0, lite_wake_i = 0, pg_stby_i = 0, pg_5v_i = 0;
  logic plt_rst_i = 0, keep_usb_i = 0, pause_soft_i = 0, dbg_plt_fail_i = 0;
  logic stby_en_o, mem_en_o, v5_en_o, v3_en_o, core_en_o, rsm_rel_o, sys_pg_o, core_pg_o, pwr_btn_o;
  logic [3:0] state_o;

  always #4 clk = ~clk;

  pwrseq_top #(.CLKS_PER_MS(K)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .pwr_on_req_i(pwr_on_req_i), .deep_wake_i(deep_wake_i),
    .lite_wake_i(lite_wake_i), .pg_stby_i(pg_stby_i), .pg_5v_i(pg_5v_i), .plt_rst_i(plt_rst_i),
    .keep_usb_i(keep_usb_i), .pause_soft_i(pause_soft_i), .dbg_plt_fail_i(dbg_plt_fail_i),
    .stby_en_o(stby_en_o), .mem_en_o(mem_en_o), .v5_en_o(v5_en_o), .v3_en_o(v3_en_o),
    .core_en_o(core_en_o), .rsm_rel_o(rsm_rel_o), .sys_pg_o(sys_pg_o), .core_pg_o(core_pg_o),
    .pwr_btn_o(pwr_btn_o), .state_o(state_o)
  );

  // monitored bits: 8 stby,7 mem,6 v5,5 v3,4 core,3 rsm,2 sys_pg,1 core_pg,0 btn
  localparam int B_STBY = 8, B_MEM = 7, B_V5 = 6, B_V3 = 5, B_CORE = 4;
  localparam int B_RSM = 3, B_SPG = 2, B_CPG = 1, B_BTN = 0;

  int cyc = 0, tests = 0, fails = 0, inv_fail = 0;
  int rise_t[9], fall_t[9], ent_t[16];
  logic [8:0] prev_m = '0;
  logic [3:0] prev_s = '0;
  wire  [8:0] mon = {stby_en_o, mem_en_o, v5_en_o, v3_en_o, core_en_o,
                     rsm_rel_o, sys_pg_o, core_pg_o, pwr_btn_o};

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    for (int i = 0; i < 9; i++) begin
      if (mon[i] && !prev_m[i]) rise_t[i] = cyc;
      if (!mon[i] && prev_m[i]) fall_t[i] = cyc;
    end
    if (state_o != prev_s) ent_t[state_o] = cyc;
    if (rst_ni && (sys_pg_o || core_pg_o) && !core_en_o) inv_fail++;
    prev_m = mon;
    prev_s = state_o;
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_st(input string req, input int code);
    int n = 0;
    while (state_o !== 4'(code) && n < 5000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 5000) chk(req, int'(state_o), code);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 outputs", int'(mon), 0);
    chk("R1 state", int'(state_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R3: standby good never arrives
    pwr_on_req_i = 1;
    wait_st("R3", 4);
    pwr_on_req_i = 0;
    wait_st("R3", 0);
    chk("R2 stby delay", rise_t[B_STBY] - ent_t[4], 10*K);
    chk("R3 stby timeout", fall_t[B_STBY] - rise_t[B_STBY], 100*K);
    chk("R3 back to off", ent_t[0], fall_t[B_STBY]);

    // R2: normal power-on to soft-off
    pg_stby_i = 1; pwr_on_req_i = 1;
    wait_st("R2", 4);
    pwr_on_req_i = 0;
    wait_st("R2", 1);
    chk("R2 stby delay", rise_t[B_STBY] - ent_t[4], 10*K);
    chk("R2 rsm after good", rise_t[B_RSM] - rise_t[B_STBY], 1);
    chk("R2 soft after rsm", ent_t[1] - rise_t[B_RSM], 10*K);

    // R4
    deep_wake_i = 1;
    wait_st("R4", 2);
    chk("R4 mem at entry", rise_t[B_MEM], ent_t[5]);
    chk("R4 susp", ent_t[2] - ent_t[5], 1);

    // R5 R6 R7
    pg_5v_i = 1; lite_wake_i = 1;
    wait_st("R5", 3);
    chk("R5 v5 at entry", rise_t[B_V5], ent_t[6]);
    chk("R5 v3 delay", rise_t[B_V3] - ent_t[6], 3*K);
    chk("R6 core after v3", rise_t[B_CORE] - rise_t[B_V3], 1);
    chk("R6 pg delay", rise_t[B_SPG] - rise_t[B_CORE], 15*K);
    chk("R6 core pg together", rise_t[B_CPG], rise_t[B_SPG]);
    chk("R7 run after poll", ent_t[3] - rise_t[B_SPG], K);
    chk("R7 sys pg held", int'(sys_pg_o), 1);

    // R8 without usb power
    lite_wake_i = 0;
    wait_st("R8", 2);
    chk("R8 pg drop", fall_t[B_SPG], ent_t[7]);
    chk("R8 core gap", fall_t[B_CORE] - ent_t[7], 5);
    chk("R8 v3 delay", fall_t[B_V3] - fall_t[B_CORE], 7*K);
    chk("R8 v5 with v3", fall_t[B_V5], fall_t[B_V3]);
    chk("R8 susp", ent_t[2], fall_t[B_V3]);

    // R8 with usb power kept
    keep_usb_i = 1; lite_wake_i = 1;
    wait_st("R8", 3);
    lite_wake_i = 0;
    wait_st("R8", 2);
    chk("R8 v5 kept", int'(v5_en_o), 1);
    chk("R8 v3 off", int'(v3_en_o), 0);
    keep_usb_i = 0;

    // R9
    pause_soft_i = 1; deep_wake_i = 0;
    wait_st("R9", 1);
    chk("R9 soft next", ent_t[1] - ent_t[8], 1);
    chk("R9 mem off", fall_t[B_MEM], ent_t[8]);
    chk("R9 v5 off", fall_t[B_V5], ent_t[8]);
    chk("R9 stby kept", int'(stby_en_o), 1);

    // R10
    pause_soft_i = 0; deep_wake_i = 1;
    wait_st("R10", 2);
    deep_wake_i = 0;
    wait_st("R10", 0);
    chk("R10 st9", ent_t[9] - ent_t[8], 1);
    chk("R10 off", ent_t[0] - ent_t[9], 1);
    chk("R10 stby off", fall_t[B_STBY], ent_t[0]);
    chk("R10 rsm off", fall_t[B_RSM], ent_t[0]);

    // R11: rail loss in run, then standby loss in suspend
    pwr_on_req_i = 1; deep_wake_i = 1; lite_wake_i = 1;
    wait_st("R11", 4);
    pwr_on_req_i = 0;
    wait_st("R11", 3);
    pg_5v_i = 0; lite_wake_i = 0;
    wait_st("R11", 2);
    chk("R11 run sys pg", fall_t[B_SPG], ent_t[7]);
    chk("R11 run rsm", fall_t[B_RSM], ent_t[7]);
    pg_stby_i = 0;
    wait_st("R11", 0);
    chk("R11 susp loss", ent_t[8] - ent_t[2] >= 1 ? 1 : 0, 1);
    chk("R11 off stby", int'(stby_en_o), 0);
    deep_wake_i = 0;

    // R12: rails not good on the way to run
    pg_stby_i = 1; pwr_on_req_i = 1; deep_wake_i = 1;
    wait_st("R12", 4);
    pwr_on_req_i = 0;
    wait_st("R12", 2);
    lite_wake_i = 1;
    wait_st("R12", 6);
    lite_wake_i = 0;
    wait_st("R12", 2);
    chk("R12 timeout", fall_t[B_V3] - rise_t[B_V3], 100*K);
    chk("R12 v5 off", fall_t[B_V5], fall_t[B_V3]);
    chk("R12 rsm off", fall_t[B_RSM], fall_t[B_V3]);
    chk("R12 susp", ent_t[2], fall_t[B_V3]);
    deep_wake_i = 0;
    wait_st("R12", 0);

    // R13: platform reset never releases
    pg_5v_i = 1; plt_rst_i = 1;
    pwr_on_req_i = 1; deep_wake_i = 1; lite_wake_i = 1;
    wait_st("R13", 6);
    pwr_on_req_i = 0;
    wait_st("R13", 3);
    chk("R13 poll window", ent_t[3] - rise_t[B_SPG], 50*K);
    chk("R13 sys pg low", int'(sys_pg_o), 0);
    chk("R13 rsm low", int'(rsm_rel_o), 0);
    plt_rst_i = 0; lite_wake_i = 0; deep_wake_i = 0; pause_soft_i = 1;
    wait_st("R13", 8);
    wait_st("R13", 4);
    wait_st("R13", 1);
    chk("R13 restart delay", rise_t[B_BTN] - ent_t[8], 100*K);
    chk("R13 btn enters up", ent_t[4], rise_t[B_BTN]);
    chk("R13 btn width", fall_t[B_BTN] - rise_t[B_BTN], 1);
    chk("R13 rsm back", int'(rsm_rel_o), 1);

    // R14: simulated timeout, once
    @(negedge clk) dbg_plt_fail_i = 1;
    @(negedge clk) dbg_plt_fail_i = 0;
    deep_wake_i = 1; lite_wake_i = 1;
    wait_st("R14", 3);
    chk("R14 early outcome", ent_t[3] - rise_t[B_SPG], K);
    chk("R14 sys pg low", int'(sys_pg_o), 0);
    lite_wake_i = 0;
    wait_st("R14", 2);
    lite_wake_i = 1;
    wait_st("R14", 3);
    chk("R14 one shot", int'(sys_pg_o), 1);
    chk("R14 normal timing", ent_t[3] - rise_t[B_SPG], K);

    chk("R6 pg implies core", inv_fail, 0);
    summary();
  end

endmodule